// File: doc/BRIEF.md
# Shift-Register Wait-State Inserter

This block lengthens bus cycles that target a slow device. A bus cycle built from four clock-wide states samples a ready line at the end of its second state and at the end of every wait state that follows; while the line is low, the sequencer keeps inserting wait states. The inserter drives that ready line for one device.

The block holds a chain of flip-flops, one stage per clock, and a stored wait setting. A cycle-start pulse clears the chain to zeros. While the device select is low, a one enters the bottom stage on every clock, so the front of ones moves up the chain and pushes the zeros out, one stage per clock period. Ready is taken from the stage chosen by the stored setting. It stays low until the front of ones reaches that stage. A setting of N, from 0 to 7, therefore holds ready low for N clock periods. The setting is captured at cycle start, so it can be routed from a decoder that changes later in the cycle. Cycles that do not select the device never see a low ready.

Ready can feed a ready synchronizer or go straight to the bus sequencer. It is combinational from select and cycle start, and registered from the chain.

Top module: `wait_inserter`

## Requirements
- R1: While reset is asserted and after it is released, the stored wait setting is 0, and ready is high until a cycle start captures a non-zero setting.
- R2: While the select input is high (device not selected), ready is high in that same clock period, and the chain is cleared at the next edge.
- R3: The wait setting input is captured only on a clock edge where cycle start is high. Changes at other times do not alter the number of wait states in the current cycle.
- R4: A captured setting of 0 keeps ready high in every clock period.
- R5: With a captured setting N from 1 to 7, cycle start high for one clock, and select low afterwards, ready is low for exactly the N clock periods that follow the cycle-start period.
- R6: Once ready has returned high with select low and no cycle start, it stays high in every later period until the next cycle start.
- R7: Ready is high in any clock period where cycle start is high. A new cycle start during the wait states restarts the full count of N from the period after it.
- R8: If select goes high during the wait states and then low again with no cycle start, ready is low for the full N periods counted from the first period in which select is low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; one period per bus state |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Device select, active low |
| cyc_start | input | 1 | High for the first state of each bus cycle (address latch strobe) |
| wait_sel | input | $clog2(STAGES) | Wait-state setting, 0 to STAGES-1 |
| rdy | output | 1 | Ready to the sequencer; low requests a wait state |

## Verification
Ready is combinational from select and cycle start, so those effects are due in the same period that the input changes. The wait count reaches ready through the chain registers and the setting register, one edge after the cycle-start period. The bench therefore drives each period's inputs just after the rising edge and samples ready at the falling edge of that same period. For every driven period, the driver queues the value that the requirements predict, and a monitor compares it at that falling edge. The N low periods are expected in the N periods that directly follow cycle start, or that follow the reselect.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  // Default chain length; the largest wait setting is one less.
  localparam int WSG_STAGES = 8;

  // Chain stage whose value ends a wait of the given length.
  function automatic int tap_index(input int waits);
    return waits - 1;
  endfunction

  // A setting of zero needs no wait states at all.
  function automatic bit no_waits(input int waits);
    return (waits == 0);
  endfunction

endpackage

// File: rtl/wsg_shift_chain.sv
module wsg_shift_chain #(
  parameter int STAGES = wsg_pkg::WSG_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  output logic [STAGES-1:0] chain
);

  // Cleared to zeros at cycle start or deselect; otherwise a one enters
  // stage 0 each clock and the zeros move up and out of the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else if (clr) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], 1'b1};
    end
  end

  // R5: the filled part of the chain only grows by one stage per clock.
  a_r5_one_stage_per_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ($countones(chain) <= $countones($past(chain)) + 1));

endmodule

// File: rtl/wsg_count_latch.sv
module wsg_count_latch #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] d,
  output logic [CW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

  // R3: the stored setting moves only on a cycle-start edge.
  a_r3_hold_between_starts: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

endmodule

// File: rtl/wsg_tap_select.sv
module wsg_tap_select #(
  parameter int STAGES = wsg_pkg::WSG_STAGES,
  parameter int CW     = $clog2(STAGES)
) (
  input  logic [STAGES-1:0] chain,
  input  logic [CW-1:0]     waits,
  output logic              tap_hi,
  output logic              bypass
);

  localparam int TAPS = STAGES - 1;

  logic [TAPS-1:0] hit;

  // One comparator per selectable tap; the setting picks at most one.
  for (genvar gi = 0; gi < TAPS; gi++) begin : g_tap
    assign hit[gi] = (int'(waits) == gi + 1) &&
                     chain[wsg_pkg::tap_index(gi + 1)];
  end

  assign tap_hi = |hit;
  assign bypass = wsg_pkg::no_waits(int'(waits));

endmodule

// File: rtl/wait_inserter.sv
module wait_inserter #(
  parameter int STAGES = wsg_pkg::WSG_STAGES,
  parameter int CW     = $clog2(STAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          cyc_start,
  input  logic [CW-1:0] wait_sel,
  output logic          rdy
);

  logic              chain_clr;
  logic [STAGES-1:0] chain;
  logic [CW-1:0]     waits_q;
  logic              waits_done;
  logic              no_wait;

  assign chain_clr = cyc_start | sel_n;

  wsg_shift_chain #(.STAGES(STAGES)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (chain_clr),
    .chain (chain)
  );

  wsg_count_latch #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cyc_start),
    .d     (wait_sel),
    .q     (waits_q)
  );

  wsg_tap_select #(.STAGES(STAGES), .CW(CW)) u_tap (
    .chain  (chain),
    .waits  (waits_q),
    .tap_hi (waits_done),
    .bypass (no_wait)
  );

  assign rdy = cyc_start | sel_n | no_wait | waits_done;

  // R2: an unselected device never holds the bus.
  a_r2_deselect_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> rdy);

  // R4: zero setting never stretches a cycle.
  a_r4_zero_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (waits_q == '0) |-> rdy);

  // R7: ready is high during the cycle-start state.
  a_r7_start_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> rdy);

  // R5: first state after cycle start is a wait when the setting is non-zero.
  a_r5_first_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cyc_start) && !cyc_start && !sel_n && waits_q != '0) |-> !rdy);

  // R6: once released, ready stays high while the device stays selected.
  a_r6_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !cyc_start && !sel_n) |=> rdy);

endmodule

// File: tb/sim_wait_inserter.sv
module sim_wait_inserter;

  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_n = 1'b1;
  logic          cyc_start = 1'b0;
  logic [CW-1:0] wait_sel = '0;
  logic          rdy;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  bit    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  wait_inserter u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .cyc_start (cyc_start),
    .wait_sel  (wait_sel),
    .rdy       (rdy)
  );

  // Drive one clock period and queue the ready value it must show.
  task automatic step(input bit st, input bit sn, input int ws,
                      input bit exp, input string tag);
    @(posedge clk);
    #1;
    cyc_start = st;
    sel_n     = sn;
    wait_sel  = CW'(ws);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // One selected cycle: start, n waits, then some released states.
  task automatic bus_cycle(input int n, input int tail);
    step(1'b1, 1'b0, n, 1'b1, "R7");
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, n, 1'b0, "R5");
    for (int i = 0; i < tail; i++)
      step(1'b0, 1'b0, n, 1'b1, (n == 0) ? "R4" : "R6");
  endtask

  // Monitor: compare at the falling edge of each driven period.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (rdy !== e) begin
        n_fail++;
        $display("FAIL %s: rdy=%b expected=%b at t=%0t", t, rdy, e, $time);
      end
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected<=5000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: ready high in reset.
    #1;
    n_checks++;
    if (rdy !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: rdy=%b expected=1 in reset", rdy);
    end
    rst_n = 1'b1;
    step(1'b0, 1'b0, 5, 1'b1, "R1");
    step(1'b0, 1'b0, 5, 1'b1, "R1");

    // R2: unselected cycle with a large setting gets no waits.
    step(1'b1, 1'b1, 5, 1'b1, "R7");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 5, 1'b1, "R2");

    // R4 / R5 / R6: every setting 0..7.
    for (int n = 0; n < 8; n++) bus_cycle(n, 3);

    // R3: setting changes after the start do not matter.
    step(1'b1, 1'b0, 3, 1'b1, "R7");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 7, 1'b0, "R3");
    step(1'b0, 1'b0, 0, 1'b1, "R3");
    step(1'b0, 1'b0, 6, 1'b1, "R3");
    step(1'b1, 1'b0, 2, 1'b1, "R7");
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 6, 1'b0, "R3");
    step(1'b0, 1'b0, 0, 1'b1, "R3");

    // R7: a new cycle start during the waits restarts the count.
    step(1'b1, 1'b0, 4, 1'b1, "R7");
    step(1'b0, 1'b0, 4, 1'b0, "R7");
    step(1'b0, 1'b0, 4, 1'b0, "R7");
    step(1'b1, 1'b0, 4, 1'b1, "R7");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 4, 1'b0, "R7");
    step(1'b0, 1'b0, 4, 1'b1, "R7");

    // R8: late select starts the count when select falls.
    step(1'b1, 1'b1, 3, 1'b1, "R7");
    step(1'b0, 1'b1, 3, 1'b1, "R8");
    step(1'b0, 1'b1, 3, 1'b1, "R8");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 3, 1'b0, "R8");
    step(1'b0, 1'b0, 3, 1'b1, "R8");

    // R8: deselect in the middle of the waits, then reselect.
    step(1'b1, 1'b0, 5, 1'b1, "R7");
    step(1'b0, 1'b0, 5, 1'b0, "R8");
    step(1'b0, 1'b0, 5, 1'b0, "R8");
    step(1'b0, 1'b1, 5, 1'b1, "R8");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 5, 1'b0, "R8");
    step(1'b0, 1'b0, 5, 1'b1, "R8");
    step(1'b0, 1'b0, 5, 1'b1, "R6");

    step(1'b0, 1'b1, 0, 1'b1, "R2");
    wait (exp_q.size() == 0);
    @(posedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule